// File: doc/BRIEF.md
# Stuck Two-Wire Bus Recovery Controller

This block watches the data and clock lines on the output side of a two-wire serial bus and detects when either line has been held low for too long. Each line has its own stuck-low timer that counts ticks of a timing strobe supplied by the caller. When a timer reaches the timeout, the block raises a fault flag. The surrounding buffer uses this flag as its request to break the connection between the input and output sides. After a guard interval the block clocks the bus with open-drain pulses on the clock line. It then finishes with a STOP condition, which resets any device that was left mid-transfer.

All timing is given as a count of the tick strobe: the timeout, the guard delay and the half period of a recovery pulse. A system design sets these to milliseconds and microseconds, and a simulation sets them to a few ticks. The block reads sampled line levels and drives pull-down enables: 1 means the line is pulled low and 0 means it is released. An enable input turns off automatic recovery. A rising edge on that input forces reconnection and starts the timeout over.

Top module: `i2c_unstick`

## Requirements
- R1: While reset is high and on the first cycle after it, sda_pull, scl_pull, fault and busy are all 0.
- R2: Each line has its own timer, and a line that goes high clears only its own timer. If the two lines take turns being low, each for less than TIMEOUT_TICKS ticks, no fault is raised. A single line held low for TIMEOUT_TICKS ticks raises fault.
- R3: When a timeout fires, fault goes to 1. With enable high, busy goes to 1 and stays 1 until the recovery sequence ends; busy is never 1 while fault is 0.
- R4: After fault rises, scl_pull stays 0 for at least GUARD_TICKS ticks before the first pulse.
- R5: Each recovery pulse pulls the clock line low for HALF_TICKS ticks and then releases it for HALF_TICKS ticks. No more than MAX_PULSES (16) pulses are driven.
- R6: If both lines read high at the end of a pulse's released half, no further pulses are driven.
- R7: After the last pulse a STOP is always driven. Both lines are pulled low for one half period. The clock line is then released while the data line stays low for one half period, and then the data line is released. busy falls when the data line is released.
- R8: After the sequence, if a line is still low, fault stays 1 and no new sequence starts. Once both lines read high, fault returns to 0.
- R9: While enable is 0, both pull outputs are 0 from the next cycle on. A sequence in progress is abandoned, busy falls and fault is kept. A timeout still raises fault but starts no clocking.
- R10: A rising edge on enable clears fault on the next cycle and restarts both timers. If a line is still low, the timeout fires again one full timeout later and recovery runs.
- R11: A line that is already low when reset is released is treated as stuck: fault rises one timeout after reset and recovery runs.
- R12: Neither pull output is 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing strobe; every timer and phase counts these pulses |
| en | input | 1 | Recovery enable; a rising edge forces reconnection |
| sda_in | input | 1 | Sampled level of the output-side data line |
| scl_in | input | 1 | Sampled level of the output-side clock line |
| sda_pull | output | 1 | Pull-down enable for the data line (1 = drive low) |
| scl_pull | output | 1 | Pull-down enable for the clock line (1 = drive low) |
| fault | output | 1 | Stuck bus detected; requests disconnection of the two sides |
| busy | output | 1 | Recovery sequence (guard, pulses, STOP) in progress |

## Verification
The bound checker watches properties on every cycle. The pull outputs stay released whenever busy is low or enable is low. busy implies fault. An enable edge clears fault. The data line is released only while the clock line has been high for the cycle before. The number of clock pulls within one sequence never exceeds the limit. The bench scenarios cover the behaviours that depend on elapsed time and on the state of the bus. These include the timeout length, the guard gap, the exact pulse count for each release point and the end of clocking once the bus frees. They also include whether fault stays set or clears after the sequence, and the timeout firing again after an enable edge.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_GUARD,
    S_PLO,
    S_PHI,
    S_STOPA,
    S_STOPB,
    S_HOLD
  } rec_state_t;
endpackage

// File: rtl/unstick_line_timer.sv
module unstick_line_timer #(
  parameter int TIMEOUT_TICKS = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rearm,
  input  logic line_in,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS);

  logic [CW-1:0] cnt;

  // Counts ticks while the line is low; only a high level or a re-arm clears it.
  always_ff @(posedge clk) begin
    if (rst || line_in || rearm) begin
      cnt <= '0;
    end else if (tick && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == LIMIT);
endmodule

// File: rtl/unstick_en_edge.sv
module unstick_en_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic en_rise
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en;
    end
  end

  assign en_rise = en && !en_q;
endmodule

// File: rtl/unstick_sequencer.sv
module unstick_sequencer
  import i2c_unstick_pkg::*;
#(
  parameter int GUARD_TICKS = 40,
  parameter int HALF_TICKS  = 59,
  parameter int MAX_PULSES  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic en_rise,
  input  logic expired_any,
  input  logic bus_high,
  output logic sda_pull,
  output logic scl_pull,
  output logic fault,
  output logic busy
);
  localparam int PH_MAX = (GUARD_TICKS > HALF_TICKS) ? GUARD_TICKS : HALF_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int PC_W   = $clog2(MAX_PULSES + 1);
  localparam logic [PH_W-1:0] GUARD_END = PH_W'(GUARD_TICKS - 1);
  localparam logic [PH_W-1:0] HALF_END  = PH_W'(HALF_TICKS - 1);
  localparam logic [PC_W-1:0] PC_LAST   = PC_W'(MAX_PULSES);

  rec_state_t       st, st_n;
  logic [PH_W-1:0]  ph, ph_n, lim;
  logic [PC_W-1:0]  np, np_n;
  logic             flt_n, step, active;

  assign lim    = (st == S_GUARD) ? GUARD_END : HALF_END;
  assign step   = tick && (ph == lim);
  assign active = (st != S_IDLE) && (st != S_HOLD);

  always_comb begin
    st_n  = st;
    np_n  = np;
    flt_n = fault;
    if (!active) begin
      ph_n = '0;
    end else if (step) begin
      ph_n = '0;
    end else if (tick) begin
      ph_n = ph + 1'b1;
    end else begin
      ph_n = ph;
    end

    case (st)
      S_IDLE: begin
        np_n = '0;
        if (expired_any && !en_rise) begin
          flt_n = 1'b1;
          st_n  = en ? S_GUARD : S_HOLD;
        end
      end
      S_GUARD: if (step) st_n = S_PLO;
      S_PLO: begin
        if (step) begin
          st_n = S_PHI;
          np_n = np + 1'b1;
        end
      end
      S_PHI: begin
        if (step) begin
          st_n = ((np == PC_LAST) || bus_high) ? S_STOPA : S_PLO;
        end
      end
      S_STOPA: if (step) st_n = S_STOPB;
      S_STOPB: if (step) st_n = S_HOLD;
      S_HOLD: begin
        if (en_rise || bus_high) begin
          flt_n = 1'b0;
          st_n  = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase

    // Enable low abandons any sequence in progress; fault is kept.
    if (!en && active) begin
      st_n = S_HOLD;
      ph_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ph       <= '0;
      np       <= '0;
      fault    <= 1'b0;
      busy     <= 1'b0;
      sda_pull <= 1'b0;
      scl_pull <= 1'b0;
    end else begin
      st       <= st_n;
      ph       <= ph_n;
      np       <= np_n;
      fault    <= flt_n;
      busy     <= (st_n != S_IDLE) && (st_n != S_HOLD);
      scl_pull <= (st_n == S_PLO) || (st_n == S_STOPA);
      sda_pull <= (st_n == S_STOPA) || (st_n == S_STOPB);
    end
  end
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
  parameter int TIMEOUT_TICKS = 30000,
  parameter int GUARD_TICKS   = 40,
  parameter int HALF_TICKS    = 59,
  parameter int MAX_PULSES    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_pull,
  output logic scl_pull,
  output logic fault,
  output logic busy
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] lines, expired;
  logic              en_rise;

  assign lines = {scl_in, sda_in};

  unstick_en_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .en_rise (en_rise)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    unstick_line_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .rearm   (en_rise),
      .line_in (lines[g]),
      .expired (expired[g])
    );
  end

  unstick_sequencer #(
    .GUARD_TICKS (GUARD_TICKS),
    .HALF_TICKS  (HALF_TICKS),
    .MAX_PULSES  (MAX_PULSES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .en          (en),
    .en_rise     (en_rise),
    .expired_any (|expired),
    .bus_high    (&lines),
    .sda_pull    (sda_pull),
    .scl_pull    (scl_pull),
    .fault       (fault),
    .busy        (busy)
  );
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 16
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic sda_pull,
  input logic scl_pull,
  input logic fault,
  input logic busy
);
  localparam int CW = $clog2(MAX_PULSES + 3);

  logic [CW-1:0] lows;
  logic          scl_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      lows  <= '0;
      scl_q <= 1'b0;
    end else begin
      scl_q <= scl_pull;
      if (scl_pull && !scl_q) lows <= lows + 1'b1;
    end
  end

  // R12: pulls only during a sequence
  p_idle_release_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_pull && !sda_pull));

  // R3: busy implies fault
  p_busy_has_fault_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> fault);

  // R9: enable low releases both lines on the next cycle
  p_en_low_release_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_pull && !sda_pull));

  // R10: enable edge clears fault
  p_en_rise_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> !fault);

  // R7: data released only with clock released on this and the previous cycle
  p_stop_order_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_pull) && $past(en)) |-> (!scl_pull && $past(!scl_pull)));

  // R5: pulses plus the STOP low never exceed the limit
  p_pulse_limit_r5: assert property (@(posedge clk) disable iff (rst)
    lows <= CW'(MAX_PULSES + 1));
endmodule

bind i2c_unstick i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .sda_pull (sda_pull),
  .scl_pull (scl_pull),
  .fault    (fault),
  .busy     (busy)
);

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 20;
  localparam int GD  = 4;
  localparam int HF  = 2;
  localparam int NP  = 16;
  localparam int DIV = 3;

  typedef struct packed {
    logic [1:0] line;   // 0 data, 1 clock, 2 both
    logic [4:0] rel;    // release after this many pulses, 0 = never
    logic [4:0] exp_p;  // expected pulse count
    logic       exp_f;  // expected fault after the sequence
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 5'd0,  5'd16, 1'b1},
    '{2'd0, 5'd3,  5'd3,  1'b0},
    '{2'd1, 5'd1,  5'd1,  1'b0},
    '{2'd2, 5'd0,  5'd16, 1'b1},
    '{2'd1, 5'd16, 5'd16, 1'b0},
    '{2'd2, 5'd7,  5'd7,  1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, en = 1'b0;
  logic hold_sda = 1'b0, hold_scl = 1'b0;
  logic sda_in, scl_in, sda_pull, scl_pull, fault, busy;
  int   nchk = 0, nfail = 0, dcnt = 0, lo_edges = 0, stop_cnt = 0;
  logic sp_q = 1'b0;

  assign sda_in = !(sda_pull || hold_sda);
  assign scl_in = !(scl_pull || hold_scl);

  i2c_unstick #(.TIMEOUT_TICKS(TO), .GUARD_TICKS(GD), .HALF_TICKS(HF), .MAX_PULSES(NP))
    i_i2c_unstick (.clk(clk), .rst(rst), .tick(tick), .en(en), .sda_in(sda_in),
                   .scl_in(scl_in), .sda_pull(sda_pull), .scl_pull(scl_pull),
                   .fault(fault), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (dcnt == DIV-1) begin dcnt <= 0; tick <= 1'b1; end
    else begin dcnt <= dcnt + 1; tick <= 1'b0; end
  end

  always @(negedge clk) begin
    if (scl_pull && !sp_q) lo_edges <= lo_edges + 1;
    if (sda_pull && !scl_pull) stop_cnt <= stop_cnt + 1;
    sp_q <= scl_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_row(input row_t r);
    int base, sbase, c, g;
    hold_sda = (r.line == 2'd0) || (r.line == 2'd2);
    hold_scl = (r.line == 2'd1) || (r.line == 2'd2);
    en = 1'b1;
    do_reset();
    base = lo_edges; sbase = stop_cnt;
    c = 0;
    while (!fault && c < 1000) begin @(negedge clk); c++; end
    chk(c >= (TO-1)*DIV && c <= (TO+1)*DIV+3, "R11 R2 timeout from reset", c, TO*DIV);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy after fault", busy, 1);
    g = 1;
    while (!scl_pull && g < 1000) begin @(negedge clk); g++; end
    chk(g >= (GD-1)*DIV, "R4 guard gap", g, GD*DIV);
    c = 0;
    while (busy && c < 5000) begin
      if (r.rel != 0 && (lo_edges - base) >= int'(r.rel)) begin
        hold_sda = 1'b0; hold_scl = 1'b0;
      end
      @(negedge clk); c++;
    end
    chk(lo_edges - base - 1 == int'(r.exp_p), "R5 R6 pulse count", lo_edges - base - 1, r.exp_p);
    chk(stop_cnt > sbase, "R7 stop driven", stop_cnt - sbase, 1);
    repeat (6) @(negedge clk);
    chk(fault == r.exp_f, "R8 fault after sequence", fault, r.exp_f);
    chk(!scl_pull && !sda_pull && !busy, "R12 lines released when idle", {scl_pull, sda_pull}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int b, c;
    bit saw;
    // R1: reset state with a stuck line present
    hold_sda = 1'b1; en = 1'b1; rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({sda_pull, scl_pull, fault, busy} == 4'b0, "R1 reset outputs", {sda_pull, scl_pull, fault, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({sda_pull, scl_pull, fault, busy} == 4'b0, "R1 first cycle after reset", {sda_pull, scl_pull, fault, busy}, 0);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

    // R2: lines low in turn, each short of the timeout
    hold_sda = 1'b0; hold_scl = 1'b0; en = 1'b1;
    do_reset();
    saw = 1'b0;
    hold_sda = 1'b1;
    repeat ((TO-4)*DIV) begin @(negedge clk); saw |= fault; end
    hold_sda = 1'b0; hold_scl = 1'b1;
    repeat ((TO-4)*DIV) begin @(negedge clk); saw |= fault; end
    hold_scl = 1'b0;
    repeat (5*DIV) begin @(negedge clk); saw |= fault; end
    chk(!saw, "R2 alternating lows raise no fault", saw, 0);

    // R9: timeout with enable low raises fault but no clocking
    en = 1'b0; hold_sda = 1'b1;
    do_reset();
    repeat ((TO+4)*DIV) @(negedge clk);
    chk(fault == 1'b1, "R9 fault with enable low", fault, 1);
    b = lo_edges; saw = 1'b0;
    repeat (40*DIV) begin @(negedge clk); saw |= busy; end
    chk(lo_edges == b && !saw, "R9 no clocking while disabled", lo_edges - b, 0);

    // R10: enable edge clears fault and restarts the timeout
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk(fault == 1'b0, "R10 enable edge clears fault", fault, 0);
    repeat ((TO-4)*DIV) @(negedge clk);
    chk(fault == 1'b0, "R10 timeout restarted", fault, 0);
    c = 0;
    while (!fault && c < 10*DIV) begin @(negedge clk); c++; end
    chk(fault == 1'b1, "R10 timeout fires again", fault, 1);
    c = 0;
    while (!scl_pull && c < 1000) begin @(negedge clk); c++; end
    chk(scl_pull == 1'b1, "R10 recovery runs after re-arm", scl_pull, 1);

    // R9: enable drop abandons the sequence but keeps fault
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy, "R9 abort releases lines", {scl_pull, sda_pull, busy}, 0);
    chk(fault == 1'b1, "R9 fault kept on abort", fault, 1);
    hold_sda = 1'b0;
    repeat (3) @(negedge clk);
    chk(fault == 1'b0, "R8 bus free clears fault", fault, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule